// File: doc/BRIEF.md
# Linked Buffer Descriptor Walker

This block runs through a chain of buffer descriptors held in system memory and turns each one into a transfer command for a downstream serial engine. Each descriptor is four 32-bit words, in this order:

- word 0 (offset 0): control;
- word 1 (offset 4): status;
- word 2 (offset 8): buffer address;
- word 3 (offset 12): next-descriptor pointer.

The walker reads these words through a single-outstanding word-read memory port. The status word is never fetched.

For each descriptor the walker:

1. decodes the control word;
2. checks that hardware owns the descriptor;
3. presents the command to the serial engine and holds it until the engine reports completion;
4. follows the next pointer.

It raises one-cycle event pulses when a descriptor completes, when a packet completes and when an invalid descriptor is met.

Software drives a 3-bit run control and a base address. Processing starts only when all three run bits are set: bit 0 is engine enable, bit 1 is poll enable and bit 2 is start. The first descriptor is read from the base address. Driving the run control to zero stops the walker from any state. After a chain ends, or after an error, the walker stays halted until the run control returns to zero. The address of the descriptor in progress is visible on `cur_addr`. Moving the data bytes is left to the serial engine.

Top module: `bd_chain_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `cmd_valid` and all events are 0 and `cur_addr` is 0. It leaves idle only when `run_ctrl` equals 3'b111; any other nonzero value issues no memory request.
- R2: For a descriptor at address A, the walker reads the control word at A, the buffer address at A+8 and the next pointer at A+12, in that order. It never has more than one read outstanding. `cur_addr` equals A while the command for that descriptor is presented.
- R3: The command takes its fields from the control word:
  - `cmd_len` is bits 8:0;
  - `cmd_recv` is bit 20;
  - `cmd_ddr` is bit 21;
  - `cmd_lsb_first` is bit 25;
  - `cmd_cs` is bits 29:28;
  - `cmd_cs_release` is bit 30;
  - `cmd_lanes` is 2'd2 when bit 23 is set (this wins over bit 22), 2'd1 when only bit 22 is set, and 2'd0 otherwise;
  - `cmd_buf_addr` is word 2.

  `cmd_valid` stays high until `cmd_done` is seen.
- R4: On completion of a descriptor whose bit 16 is set, `evt_desc_done` pulses for one cycle.
- R5: `evt_pkt_done` pulses on completion only when both bit 19 and bit 17 are set. Bit 17 without bit 19 gives no pulse.
- R6: After a descriptor completes, the walker continues at its next pointer. The chain ends, and `busy` falls, when bit 19 is set (even with a nonzero next pointer) or when the next pointer is zero.
- R7: A control word with bit 31 clear while poll enable (`run_ctrl[1]`) is set is re-read until bit 31 is found set. No command is issued meanwhile.
- R8: A control word with bit 31 clear while poll enable is clear pulses `evt_error` and halts without issuing a command.
- R9: An owned descriptor whose length field exceeds 256 pulses `evt_error` and halts without issuing a command.
- R10: `run_ctrl` equal to zero returns the walker to idle at the next clock edge from any state, and drops `cmd_valid`.
- R11: After a chain end or an error, the walker issues no further memory reads while `run_ctrl` stays nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_ctrl | input | 3 | Run control: bit 0 engine enable, bit 1 poll enable, bit 2 start |
| base_addr | input | AW | Address of the first descriptor |
| cur_addr | output | AW | Address of the descriptor in progress |
| busy | output | 1 | High while a chain is being walked |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command presented to the serial engine |
| cmd_buf_addr | output | AW | Buffer address of the transfer |
| cmd_len | output | 9 | Transfer length in bytes |
| cmd_recv | output | 1 | 1 = receive, 0 = transmit |
| cmd_ddr | output | 1 | Double data rate transfer |
| cmd_lanes | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_lsb_first | output | 1 | Least significant bit first |
| cmd_cs | output | 2 | Device select |
| cmd_cs_release | output | 1 | Release chip select after this transfer |
| cmd_done | input | 1 | Serial engine finished the command |
| evt_desc_done | output | 1 | Descriptor-complete pulse |
| evt_pkt_done | output | 1 | Packet-complete pulse |
| evt_error | output | 1 | Invalid-descriptor pulse |

## Verification
A read request is answered one cycle later by the bench memory. The captured word changes state at the edge that sees `mem_rvalid`, so a command appears three read round trips after the start edge. Event pulses and the fall of `busy` both appear in the cycle after the edge that sees `cmd_done`, or after the edge that captures a bad control word. The bench therefore waits at falling edges until `busy` drops, then lets two more falling edges pass before it compares event and command counts. Effects of the run control are checked at the falling edge that follows the next rising edge.

// File: rtl/bdw_pkg.sv
package bdw_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 9;
    localparam int MAX_LEN = 256;

    // control word bit positions (descriptor format)
    localparam int B_IRQ_DESC = 16;
    localparam int B_IRQ_PKT  = 17;
    localparam int B_END      = 19;
    localparam int B_RECV     = 20;
    localparam int B_DDR      = 21;
    localparam int B_DUAL     = 22;
    localparam int B_QUAD     = 23;
    localparam int B_LSB      = 25;
    localparam int B_CS_LO    = 28;
    localparam int B_CS_DROP  = 30;
    localparam int B_OWNED    = 31;

    // word byte offsets inside one descriptor
    localparam int OFS_CTRL = 0;
    localparam int OFS_BUF  = 8;
    localparam int OFS_NEXT = 12;

    typedef enum logic [1:0] {
        LANES_X1 = 2'd0,
        LANES_X2 = 2'd1,
        LANES_X4 = 2'd2
    } lanes_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_XFER,
        ST_HALT
    } walk_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             recv;
        logic             ddr;
        lanes_e           lanes;
        logic             lsb_first;
        logic [1:0]       cs;
        logic             cs_drop;
    } xfer_attr_t;

    typedef struct packed {
        logic owned;
        logic list_end;
        logic irq_desc;
        logic irq_pkt;
        logic len_bad;
    } desc_flags_t;

    function automatic lanes_e pick_lanes(input logic quad, input logic dual);
        if (quad)      return LANES_X4;
        else if (dual) return LANES_X2;
        else           return LANES_X1;
    endfunction

    function automatic xfer_attr_t decode_attr(input logic [WORD_W-1:0] w);
        xfer_attr_t a;
        a.len       = w[LEN_W-1:0];
        a.recv      = w[B_RECV];
        a.ddr       = w[B_DDR];
        a.lanes     = pick_lanes(w[B_QUAD], w[B_DUAL]);
        a.lsb_first = w[B_LSB];
        a.cs        = w[B_CS_LO +: 2];
        a.cs_drop   = w[B_CS_DROP];
        return a;
    endfunction

    function automatic desc_flags_t decode_flags(input logic [WORD_W-1:0] w);
        desc_flags_t f;
        f.owned    = w[B_OWNED];
        f.list_end = w[B_END];
        f.irq_desc = w[B_IRQ_DESC];
        f.irq_pkt  = w[B_IRQ_PKT];
        f.len_bad  = (w[LEN_W-1:0] > LEN_W'(MAX_LEN));
        return f;
    endfunction

endpackage

// File: rtl/bdw_mem_port.sv
module bdw_mem_port #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          rd_want,
    input  logic [AW-1:0] rd_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          word_valid,
    output logic [DW-1:0] word_data
);

    logic pending;

    assign mem_req    = rd_want && !pending && !flush;
    assign mem_addr   = rd_addr;
    assign word_valid = pending && mem_rvalid;
    assign word_data  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pending <= 1'b0;
        end else if (mem_req) begin
            pending <= 1'b1;
        end else if (mem_rvalid) begin
            pending <= 1'b0;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req) else $error("second read issued while one outstanding"); // R2

endmodule

// File: rtl/bdw_event_gen.sv
module bdw_event_gen (
    input  logic clk,
    input  logic rst,
    input  logic done_fire,
    input  logic err_fire,
    input  logic irq_desc,
    input  logic pkt_hit,
    output logic evt_desc_done,
    output logic evt_pkt_done,
    output logic evt_error
);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_desc_done <= 1'b0;
            evt_pkt_done  <= 1'b0;
            evt_error     <= 1'b0;
        end else begin
            evt_desc_done <= done_fire && irq_desc;
            evt_pkt_done  <= done_fire && pkt_hit;
            evt_error     <= err_fire;
        end
    end

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        evt_error |-> !(evt_desc_done || evt_pkt_done)) else $error("error event with completion event"); // R8

    AST_DESC_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_desc_done |=> !evt_desc_done) else $error("descriptor event longer than one cycle"); // R4

endmodule

// File: rtl/bd_chain_walker.sv
module bd_chain_walker
    import bdw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        run_ctrl,
    input  logic [AW-1:0]     base_addr,
    output logic [AW-1:0]     cur_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cmd_valid,
    output logic [AW-1:0]     cmd_buf_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_recv,
    output logic              cmd_ddr,
    output logic [1:0]        cmd_lanes,
    output logic              cmd_lsb_first,
    output logic [1:0]        cmd_cs,
    output logic              cmd_cs_release,
    input  logic              cmd_done,
    output logic              evt_desc_done,
    output logic              evt_pkt_done,
    output logic              evt_error
);

    localparam logic [AW-1:0] NULL_PTR = '0;

    walk_state_e   state;
    logic [AW-1:0] cur, buf_ptr, next_ptr;
    xfer_attr_t    attr;
    logic          end_flag, irq_desc_flag, irq_pkt_flag;

    logic          abort, start_ok, poll_en;
    logic          rd_want;
    logic [AW-1:0] rd_addr;
    logic          word_valid;
    logic [WORD_W-1:0] word_data;
    desc_flags_t   fl_now;
    logic          err_fire, done_fire, chain_stop;

    assign abort    = (run_ctrl == 3'b000);
    assign start_ok = (run_ctrl == 3'b111);
    assign poll_en  = run_ctrl[1];

    always_comb begin
        rd_want = 1'b1;
        rd_addr = cur;
        case (state)
            ST_RD_CTRL: rd_addr = cur + AW'(OFS_CTRL);
            ST_RD_BUF:  rd_addr = cur + AW'(OFS_BUF);
            ST_RD_NEXT: rd_addr = cur + AW'(OFS_NEXT);
            default:    rd_want = 1'b0;
        endcase
    end

    bdw_mem_port #(.AW(AW), .DW(WORD_W)) u_mem_port (
        .clk        (clk),
        .rst        (rst),
        .flush      (abort),
        .rd_want    (rd_want),
        .rd_addr    (rd_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    assign fl_now     = decode_flags(word_data);
    assign chain_stop = end_flag || (next_ptr == NULL_PTR);
    assign err_fire   = (state == ST_RD_CTRL) && word_valid && !abort &&
                        ((!fl_now.owned && !poll_en) || (fl_now.owned && fl_now.len_bad));
    assign done_fire  = (state == ST_XFER) && cmd_done && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cur           <= '0;
            buf_ptr       <= '0;
            next_ptr      <= '0;
            attr          <= '0;
            end_flag      <= 1'b0;
            irq_desc_flag <= 1'b0;
            irq_pkt_flag  <= 1'b0;
        end else if (abort) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        cur   <= base_addr;
                        state <= ST_RD_CTRL;
                    end
                end
                ST_RD_CTRL: begin
                    if (word_valid) begin
                        attr          <= decode_attr(word_data);
                        end_flag      <= fl_now.list_end;
                        irq_desc_flag <= fl_now.irq_desc;
                        irq_pkt_flag  <= fl_now.irq_pkt;
                        if (err_fire)
                            state <= ST_HALT;
                        else if (fl_now.owned)
                            state <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: begin
                    if (word_valid) begin
                        buf_ptr <= word_data[AW-1:0];
                        state   <= ST_RD_NEXT;
                    end
                end
                ST_RD_NEXT: begin
                    if (word_valid) begin
                        next_ptr <= word_data[AW-1:0];
                        state    <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (cmd_done) begin
                        if (chain_stop) begin
                            state <= ST_HALT;
                        end else begin
                            cur   <= next_ptr;
                            state <= ST_RD_CTRL;
                        end
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    bdw_event_gen u_events (
        .clk           (clk),
        .rst           (rst),
        .done_fire     (done_fire),
        .err_fire      (err_fire),
        .irq_desc      (irq_desc_flag),
        .pkt_hit       (irq_pkt_flag && end_flag),
        .evt_desc_done (evt_desc_done),
        .evt_pkt_done  (evt_pkt_done),
        .evt_error     (evt_error)
    );

    assign cur_addr       = cur;
    assign busy           = (state != ST_IDLE) && (state != ST_HALT);
    assign cmd_valid      = (state == ST_XFER);
    assign cmd_buf_addr   = buf_ptr;
    assign cmd_len        = attr.len;
    assign cmd_recv       = attr.recv;
    assign cmd_ddr        = attr.ddr;
    assign cmd_lanes      = attr.lanes;
    assign cmd_lsb_first  = attr.lsb_first;
    assign cmd_cs         = attr.cs;
    assign cmd_cs_release = attr.cs_drop;

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done && run_ctrl != 3'b000) |=> cmd_valid) else $error("command dropped early"); // R3

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> ($stable(cmd_buf_addr) && $stable(cur_addr))) else $error("command changed while held"); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (run_ctrl == 3'b000) |=> (!busy && !cmd_valid)) else $error("stop did not return to idle"); // R10

    AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (!busy && run_ctrl != 3'b111) |-> !mem_req) else $error("read issued while not walking"); // R11

endmodule

// File: tb/bd_chain_walker_tb.sv
module bd_chain_walker_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    run_ctrl;
    logic [AW-1:0] base_addr;
    logic [AW-1:0] cur_addr;
    logic          busy, mem_req, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          cmd_valid, cmd_recv, cmd_ddr, cmd_lsb_first, cmd_cs_release, cmd_done;
    logic [AW-1:0] cmd_buf_addr;
    logic [8:0]    cmd_len;
    logic [1:0]    cmd_lanes, cmd_cs;
    logic          evt_desc_done, evt_pkt_done, evt_error;

    always #(CLK_PERIOD/2) clk = ~clk;

    bd_chain_walker #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .run_ctrl(run_ctrl), .base_addr(base_addr),
        .cur_addr(cur_addr), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
        .cmd_buf_addr(cmd_buf_addr), .cmd_len(cmd_len), .cmd_recv(cmd_recv),
        .cmd_ddr(cmd_ddr), .cmd_lanes(cmd_lanes), .cmd_lsb_first(cmd_lsb_first),
        .cmd_cs(cmd_cs), .cmd_cs_release(cmd_cs_release), .cmd_done(cmd_done),
        .evt_desc_done(evt_desc_done), .evt_pkt_done(evt_pkt_done), .evt_error(evt_error)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] mem [64];

    int          nreq = 0;
    logic [31:0] req_log [512];
    int          ncmd = 0;
    logic [31:0] c_buf [64];
    logic [31:0] c_cur [64];
    logic [8:0]  c_len [64];
    logic [1:0]  c_lanes [64];
    logic [1:0]  c_cs [64];
    logic        c_recv [64];
    logic        c_ddr [64];
    logic        c_lsb [64];
    logic        c_drop [64];
    int          n_desc = 0, n_pkt = 0, n_err = 0;
    bit          eng_stall = 0;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [2:0]  after;
        logic [3:0]  cmds;
        logic [8:0]  len;
        logic [1:0]  lanes;
        logic [1:0]  cs;
        logic        recv;
        logic        ddr;
        logic        lsb;
        logic        drop;
        logic        desc;
        logic        pkt;
        logic        err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{32'h8001_0010, 3'd7, 4'd1, 9'd16,  2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h80BB_0100, 3'd7, 4'd1, 9'd256, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{32'hD2C2_0005, 3'd7, 4'd1, 9'd5,   2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'hA042_0001, 3'd7, 4'd1, 9'd1,   2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h0001_0010, 3'd5, 4'd0, 9'd0,   2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h8001_0101, 3'd7, 4'd0, 9'd0,   2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h8018_0020, 3'd7, 4'd1, 9'd32,  2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    // memory model: answers a request one cycle later
    initial begin
        bit          due;
        logic [31:0] due_addr;
        due = 0;
        due_addr = '0;
        mem_rvalid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (due) begin
                mem_rvalid = 1'b1;
                mem_rdata = mem[due_addr[7:2]];
                due = 0;
            end
            if (mem_req) begin
                due = 1;
                due_addr = mem_addr;
                if (nreq < 512) req_log[nreq] = mem_addr;
                nreq++;
            end
        end
    end

    // serial engine model: finishes three cycles after the command appears
    initial begin
        int cnt;
        cnt = 0;
        cmd_done = 1'b0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (cmd_valid && !eng_stall) begin
                cnt++;
                if (cnt == 3) begin
                    cmd_done = 1'b1;
                    cnt = 0;
                    if (ncmd < 64) begin
                        c_buf[ncmd] = cmd_buf_addr;  c_cur[ncmd] = cur_addr;
                        c_len[ncmd] = cmd_len;       c_lanes[ncmd] = cmd_lanes;
                        c_cs[ncmd] = cmd_cs;         c_recv[ncmd] = cmd_recv;
                        c_ddr[ncmd] = cmd_ddr;       c_lsb[ncmd] = cmd_lsb_first;
                        c_drop[ncmd] = cmd_cs_release;
                    end
                    ncmd++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (evt_desc_done) n_desc++;
            if (evt_pkt_done)  n_pkt++;
            if (evt_error)     n_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_chain(input logic [31:0] base, input logic [2:0] after);
        base_addr = base;
        run_ctrl = 3'b111;
        @(negedge clk);
        run_ctrl = after;
        wait_idle();
    endtask

    task automatic stop_walk();
        run_ctrl = 3'b000;
        @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 64; k++) mem[k] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int s_req, s_cmd, s_d, s_p, s_e;
        rst = 1'b1;
        run_ctrl = 3'b000;
        base_addr = '0;
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !mem_req && !cmd_valid, "R1 reset idle", {busy, mem_req, cmd_valid}, 0);
        chk(!evt_desc_done && !evt_pkt_done && !evt_error, "R1 reset events", {evt_desc_done, evt_pkt_done, evt_error}, 0);
        chk(cur_addr == 0, "R1 reset cur_addr", cur_addr, 0);

        // R1 partial run control does not start
        s_req = nreq;
        base_addr = 32'h40;
        run_ctrl = 3'b011;
        repeat (6) @(negedge clk);
        chk(nreq == s_req && !busy, "R1 partial start", nreq - s_req, 0);
        stop_walk();

        // table of single-descriptor chains (next pointer zero)
        for (int i = 0; i < NV; i++) begin
            clear_mem();
            mem[16] = VEC[i].ctrl;
            mem[18] = 32'h1000 + i;
            mem[19] = 32'h0;
            s_req = nreq; s_cmd = ncmd; s_d = n_desc; s_p = n_pkt; s_e = n_err;
            run_chain(32'h40, VEC[i].after);
            chk(ncmd - s_cmd == VEC[i].cmds, "R6/R8/R9 command count", ncmd - s_cmd, VEC[i].cmds);
            chk(n_err - s_e == VEC[i].err, "R8/R9 error event", n_err - s_e, VEC[i].err);
            chk(n_desc - s_d == VEC[i].desc, "R4 descriptor event", n_desc - s_d, VEC[i].desc);
            chk(n_pkt - s_p == VEC[i].pkt, "R5 packet event", n_pkt - s_p, VEC[i].pkt);
            chk(!busy, "R6 null pointer ends chain", busy, 0);
            if (VEC[i].cmds != 0) begin
                chk(nreq - s_req == 3, "R2 read count", nreq - s_req, 3);
                chk(req_log[s_req] == 32'h40 && req_log[s_req+1] == 32'h48 && req_log[s_req+2] == 32'h4C,
                    "R2 read order", req_log[s_req+1], 32'h48);
                chk(c_buf[s_cmd] == 32'h1000 + i, "R3 buffer address", c_buf[s_cmd], 32'h1000 + i);
                chk(c_len[s_cmd] == VEC[i].len, "R3 length", c_len[s_cmd], VEC[i].len);
                chk(c_lanes[s_cmd] == VEC[i].lanes, "R3 lanes", c_lanes[s_cmd], VEC[i].lanes);
                chk(c_cs[s_cmd] == VEC[i].cs, "R3 device select", c_cs[s_cmd], VEC[i].cs);
                chk({c_recv[s_cmd], c_ddr[s_cmd], c_lsb[s_cmd], c_drop[s_cmd]} ==
                    {VEC[i].recv, VEC[i].ddr, VEC[i].lsb, VEC[i].drop}, "R3 flags",
                    {c_recv[s_cmd], c_ddr[s_cmd], c_lsb[s_cmd], c_drop[s_cmd]},
                    {VEC[i].recv, VEC[i].ddr, VEC[i].lsb, VEC[i].drop});
            end else begin
                chk(nreq - s_req == 1, "R8/R9 only control read", nreq - s_req, 1);
            end
            stop_walk();
        end

        // R6 three-descriptor chain, last one flagged end with nonzero next
        clear_mem();
        mem[32] = 32'h8001_0008; mem[34] = 32'h2000; mem[35] = 32'hC0;
        mem[48] = 32'h8001_0010; mem[50] = 32'h2100; mem[51] = 32'h20;
        mem[8]  = 32'h800B_0018; mem[10] = 32'h2200; mem[11] = 32'h90;
        s_req = nreq; s_cmd = ncmd; s_d = n_desc; s_p = n_pkt;
        run_chain(32'h80, 3'b111);
        chk(ncmd - s_cmd == 3, "R6 chain length", ncmd - s_cmd, 3);
        chk(c_buf[s_cmd] == 32'h2000 && c_buf[s_cmd+1] == 32'h2100 && c_buf[s_cmd+2] == 32'h2200,
            "R6 chain order", c_buf[s_cmd+2], 32'h2200);
        chk(c_cur[s_cmd] == 32'h80 && c_cur[s_cmd+1] == 32'hC0 && c_cur[s_cmd+2] == 32'h20,
            "R2 cur_addr per descriptor", c_cur[s_cmd+1], 32'hC0);
        chk(req_log[s_req+3] == 32'hC0 && req_log[s_req+6] == 32'h20, "R2 follows next", req_log[s_req+6], 32'h20);
        chk(nreq - s_req == 9, "R6 stop at end flag", nreq - s_req, 9);
        chk(n_desc - s_d == 3, "R4 event per descriptor", n_desc - s_d, 3);
        chk(n_pkt - s_p == 1, "R5 packet event at end", n_pkt - s_p, 1);
        // R11 stays halted while run control remains set
        s_req = nreq;
        repeat (10) @(negedge clk);
        chk(nreq == s_req && !busy, "R11 no restart", nreq - s_req, 0);
        stop_walk();

        // R7 polling an unowned descriptor
        clear_mem();
        mem[16] = 32'h0001_0004; mem[18] = 32'h3000;
        s_req = nreq; s_cmd = ncmd; s_d = n_desc; s_e = n_err;
        base_addr = 32'h40;
        run_ctrl = 3'b111;
        repeat (20) @(negedge clk);
        chk(busy && ncmd == s_cmd && n_err == s_e, "R7 waits without command", ncmd - s_cmd, 0);
        chk(nreq - s_req >= 5, "R7 control re-read", nreq - s_req, 5);
        mem[16] = 32'h8001_0004;
        wait_idle();
        chk(ncmd - s_cmd == 1 && c_buf[s_cmd] == 32'h3000, "R7 proceeds once owned", ncmd - s_cmd, 1);
        chk(n_desc - s_d == 1, "R7 completion event", n_desc - s_d, 1);
        stop_walk();

        // R10 stop while a command is held
        clear_mem();
        mem[16] = 32'h8001_0008; mem[18] = 32'h4000;
        eng_stall = 1;
        s_cmd = ncmd; s_d = n_desc;
        base_addr = 32'h40;
        run_ctrl = 3'b111;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (cmd_valid) break;
        end
        chk(cmd_valid, "R10 command presented", cmd_valid, 1);
        run_ctrl = 3'b000;
        @(negedge clk);
        chk(!cmd_valid && !busy, "R10 stop to idle", {cmd_valid, busy}, 0);
        eng_stall = 0;
        repeat (3) @(negedge clk);
        chk(ncmd == s_cmd && n_desc == s_d, "R10 no completion after stop", ncmd - s_cmd, 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule